// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control state of a processor core: stack pointers for each mode, the interrupt priority level, the pending and enabled asynchronous trap bits, the software interrupt summary, the machine check summary, several table base pointers and the processor number. Software reaches it through a single command port. Each command is either a move-from (read) or a move-to (write), and it carries a 5-bit register index and, for writes, a 64-bit value. The port accepts one command per cycle. One cycle after the command, a registered response returns the read data or, for some writes, the previous contents. Illegal accesses are flagged with an error.

The registers do not all behave the same way. Each index has its own sign-extension width on read, its own merge rule on write and its own permission. The trap registers take a clear mask and a set mask in one write. The machine check summary clears the bits selected by the value. A write to the software request index posts one bit into the summary. Access to the kernel stack pointer depends on a privileged-mode input, and two memory management registers depend on a feature input. A write to any translation buffer invalidate index does not change state here. Instead it raises a one-cycle flush pulse, which a separate translation buffer consumes.

Top module: `pcr_file`

## Requirements
- R1: During and after reset, `rsp_valid`, `rsp_error`, `rsp_old` and `flush_pulse` are 0. The reset contents are: priority level 5'h1F, processor number 3, page table base 64'h400000, context block base 48'h8000_0000_1000, address space number 8'h2A, and every other stored field 0.
- R2: A command presented with `cmd_valid` produces `rsp_valid` exactly one cycle later. The indices are: 0 address space number, 1 trap enable, 2 trap pending, 3 FPU enable, 4 interprocessor request, 5 priority level, 6 kernel stack, 7 machine check summary, 8 context block base, 9 per-CPU base, 10 page table base, 11 vector table base, 12 software interrupt request, 13 software interrupt summary, 14 supervisor stack, 15 system page table base, 16 TB probe, 17 flush all, 18 flush process, 19 flush one, 20 flush one data, 21 flush one instruction, 22 user stack, 23 virtual bound, 24 virtual page table base, 25 processor number, 26 executive stack. The 64-bit indices 6, 9, 14, 15, 22, 23, 24 and 26 store the full value and read it back unchanged.
- R3: A write to index 1 or 2 replaces the 4-bit field with (old AND val[3:0]) OR val[7:4]. It returns the old 4-bit field zero-extended, with `rsp_old` set. A read returns the field sign-extended from bit 3.
- R4: A write to index 5 stores val[4:0]. It returns the old level sign-extended from bit 4, with `rsp_old` set. A read returns the level sign-extended from bit 4.
- R5: A write to index 12 with val[3:0] nonzero sets bit val[3:0] of the 16-bit software interrupt summary. When val[3:0] is zero, the summary is left unchanged.
- R6: A write to index 7 clears summary bits [2:0] wherever val[2:0] is 1, and loads bits [4:3] from val[4:3]. A read sign-extends the summary from bit 4.
- R7: A read of the FPU enable returns the stored bit (written from val[0]) sign-extended from bit 0. The context block base is sign-extended from bit 47. The vector table base keeps val[31:0] on write and is sign-extended from bit 31 on read. The software interrupt summary is sign-extended from bit 15.
- R8: A read of index 4, 12, 17, 18, 19, 20 or 21 sets `rsp_error` and returns 0.
- R9: A write to index 0, 8, 10, 13, 16 or 25 sets `rsp_error` and changes no state. A read of index 16 returns 0 without error.
- R10: A read or write of index 6 while `pal_mode` is 0 sets `rsp_error` and changes nothing.
- R11: Indices 15 and 23 flag `rsp_error` on read and on write while `feat_vmext` is 0. Index 0 reads as 0 while `feat_asn` is 0.
- R12: A write to indices 17–21 raises `flush_pulse` for one cycle, aligned with its response. `flush_single` is 1 for indices 19–21, and only then does `flush_addr` carry the written value.
- R13: Indices 27–31 flag `rsp_error` on read and on write, return 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| cmd_index | input | 5 | Register index |
| cmd_wdata | input | 64 | Write value |
| pal_mode | input | 1 | Privileged-mode state; gates the kernel stack pointer |
| feat_asn | input | 1 | Address space number is implemented |
| feat_vmext | input | 1 | System page table base and virtual bound are implemented |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_data | output | 64 | Read data or previous value; 0 otherwise |
| rsp_old | output | 1 | `rsp_data` holds a previous value returned by a write |
| rsp_error | output | 1 | Illegal access |
| flush_pulse | output | 1 | Translation buffer invalidate request |
| flush_single | output | 1 | Invalidate one page rather than all |
| flush_addr | output | 64 | Page address for a single-page invalidate |

## Verification
Two things can meet in the same cycle. A write changes the stored field at the same edge that its response returns the pre-write contents, and a read issued in the very next cycle must already see the new value. Commands are therefore driven back to back, with no idle cycles between them. Random sequences often hit the same index twice in a row, and directed pairs force the case: write priority then read priority, post a software interrupt then read the summary. For each pair, the returned old value and the following read are compared against a reference model in the bench that is updated in command order.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  localparam int IDX_W  = 5;
  localparam int DATA_W = 64;
  localparam int WIDE_N = 8;
  localparam int SLOT_W = $clog2(WIDE_N);

  typedef enum logic [IDX_W-1:0] {
    IX_ASPACE    = 5'd0,
    IX_TRAP_EN   = 5'd1,
    IX_TRAP_PEND = 5'd2,
    IX_FPU_EN    = 5'd3,
    IX_IPI_REQ   = 5'd4,
    IX_PRIO      = 5'd5,
    IX_KSTACK    = 5'd6,
    IX_MCHK      = 5'd7,
    IX_CTXBLK    = 5'd8,
    IX_CPU_BASE  = 5'd9,
    IX_PGTBL     = 5'd10,
    IX_VEC_BASE  = 5'd11,
    IX_SWI_REQ   = 5'd12,
    IX_SWI_SUM   = 5'd13,
    IX_SSTACK    = 5'd14,
    IX_SYS_PGTBL = 5'd15,
    IX_TB_PROBE  = 5'd16,
    IX_FL_ALL    = 5'd17,
    IX_FL_PROC   = 5'd18,
    IX_FL_ONE    = 5'd19,
    IX_FL_ONE_D  = 5'd20,
    IX_FL_ONE_I  = 5'd21,
    IX_USTACK    = 5'd22,
    IX_VA_BOUND  = 5'd23,
    IX_VPT_BASE  = 5'd24,
    IX_CPU_ID    = 5'd25,
    IX_ESTACK    = 5'd26
  } pcr_idx_e;

  // Replicate bit msb of v into every bit above it.
  function automatic logic [DATA_W-1:0] sext_at(input logic [DATA_W-1:0] v,
                                                input int unsigned msb);
    logic [DATA_W-1:0] hi;
    hi = {DATA_W{1'b1}} << msb;
    return v[msb] ? (v | hi) : (v & ~hi);
  endfunction

  // Clear mask in the low nibble, set mask in the next nibble.
  function automatic logic [3:0] trap_merge(input logic [3:0] cur,
                                            input logic [DATA_W-1:0] v);
    return (cur & v[3:0]) | v[7:4];
  endfunction

  // Write-one-to-clear on [2:0], direct load on [4:3].
  function automatic logic [4:0] mchk_merge(input logic [4:0] cur,
                                            input logic [DATA_W-1:0] v);
    return {v[4:3], cur[2:0] & ~v[2:0]};
  endfunction

  // Post software interrupt level v[3:0]; level 0 posts nothing.
  function automatic logic [15:0] swi_post(input logic [15:0] cur,
                                           input logic [DATA_W-1:0] v);
    logic [15:0] bitsel;
    bitsel = 16'(1) << v[3:0];
    return (v[3:0] != 4'd0) ? (cur | bitsel) : cur;
  endfunction

  // Map full-width indices to storage slots: {hit, slot}.
  function automatic logic [SLOT_W:0] wide_slot(input logic [IDX_W-1:0] ix);
    case (ix)
      IX_KSTACK:    return {1'b1, 3'd0};
      IX_CPU_BASE:  return {1'b1, 3'd1};
      IX_SSTACK:    return {1'b1, 3'd2};
      IX_SYS_PGTBL: return {1'b1, 3'd3};
      IX_USTACK:    return {1'b1, 3'd4};
      IX_VA_BOUND:  return {1'b1, 3'd5};
      IX_VPT_BASE:  return {1'b1, 3'd6};
      IX_ESTACK:    return {1'b1, 3'd7};
      default:      return '0;
    endcase
  endfunction

endpackage

// File: rtl/pcr_access.sv
module pcr_access
  import pcr_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             is_write,
  input  logic             pal_mode,
  input  logic             feat_vmext,
  output logic             access_err,
  output logic             has_old,
  output logic             flush_hit,
  output logic             flush_one
);

  always_comb begin
    access_err = 1'b0;
    has_old    = 1'b0;
    flush_hit  = 1'b0;
    flush_one  = 1'b0;
    case (idx)
      IX_TRAP_EN, IX_TRAP_PEND, IX_PRIO:
        has_old = is_write;
      IX_FPU_EN, IX_MCHK, IX_CPU_BASE, IX_VEC_BASE,
      IX_SSTACK, IX_USTACK, IX_VPT_BASE, IX_ESTACK:
        access_err = 1'b0;
      IX_IPI_REQ, IX_SWI_REQ:
        access_err = !is_write;
      IX_FL_ALL, IX_FL_PROC: begin
        access_err = !is_write;
        flush_hit  = is_write;
      end
      IX_FL_ONE, IX_FL_ONE_D, IX_FL_ONE_I: begin
        access_err = !is_write;
        flush_hit  = is_write;
        flush_one  = is_write;
      end
      IX_ASPACE, IX_CTXBLK, IX_PGTBL, IX_SWI_SUM, IX_TB_PROBE, IX_CPU_ID:
        access_err = is_write;
      IX_KSTACK:
        access_err = !pal_mode;
      IX_SYS_PGTBL, IX_VA_BOUND:
        access_err = !feat_vmext;
      default:
        access_err = 1'b1;
    endcase
  end

endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
  import pcr_pkg::*;
#(
  parameter int                 ASN_W       = 8,
  parameter int                 CTX_W       = 48,
  parameter int                 VEC_W       = 32,
  parameter logic [ASN_W-1:0]   ASN_INIT    = 8'h2A,
  parameter logic [CTX_W-1:0]   CTX_INIT    = 48'h8000_0000_1000,
  parameter logic [DATA_W-1:0]  PGTBL_INIT  = 64'h0000_0000_0040_0000,
  parameter logic [DATA_W-1:0]  CPU_ID_INIT = 64'h3,
  parameter logic [4:0]         PRIO_INIT   = 5'h1F
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              feat_asn,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] old_val
);

  localparam int CTX_MSB = CTX_W - 1;
  localparam int VEC_MSB = VEC_W - 1;

  logic [3:0]        trap_en_q, trap_pend_q;
  logic              fpu_q;
  logic [4:0]        prio_q, mchk_q;
  logic [VEC_W-1:0]  vec_q;
  logic [15:0]       swi_q;
  logic [DATA_W-1:0] wide_q [WIDE_N];

  logic [SLOT_W:0]   slot;
  logic              wr_trap_en, wr_trap_pend, wr_prio, wr_mchk, wr_swi;

  assign slot         = wide_slot(idx);
  assign wr_trap_en   = wr_en && (idx == IX_TRAP_EN);
  assign wr_trap_pend = wr_en && (idx == IX_TRAP_PEND);
  assign wr_prio      = wr_en && (idx == IX_PRIO);
  assign wr_mchk      = wr_en && (idx == IX_MCHK);
  assign wr_swi       = wr_en && (idx == IX_SWI_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_en_q   <= '0;
      trap_pend_q <= '0;
      fpu_q       <= 1'b0;
      prio_q      <= PRIO_INIT;
      mchk_q      <= '0;
      vec_q       <= '0;
      swi_q       <= '0;
    end else begin
      if (wr_trap_en)   trap_en_q   <= trap_merge(trap_en_q, wdata);
      if (wr_trap_pend) trap_pend_q <= trap_merge(trap_pend_q, wdata);
      if (wr_en && idx == IX_FPU_EN)   fpu_q <= wdata[0];
      if (wr_prio)      prio_q      <= wdata[4:0];
      if (wr_mchk)      mchk_q      <= mchk_merge(mchk_q, wdata);
      if (wr_en && idx == IX_VEC_BASE) vec_q <= wdata[VEC_W-1:0];
      if (wr_swi)       swi_q       <= swi_post(swi_q, wdata);
    end
  end

  for (genvar g = 0; g < WIDE_N; g++) begin : g_wide
    always_ff @(posedge clk) begin
      if (!rst_n)
        wide_q[g] <= '0;
      else if (wr_en && slot[SLOT_W] && slot[SLOT_W-1:0] == SLOT_W'(g))
        wide_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (slot[SLOT_W]) begin
      rd_val = wide_q[slot[SLOT_W-1:0]];
    end else begin
      case (idx)
        IX_ASPACE:    rd_val = feat_asn ? DATA_W'(ASN_INIT) : '0;
        IX_TRAP_EN:   rd_val = sext_at(DATA_W'(trap_en_q), 3);
        IX_TRAP_PEND: rd_val = sext_at(DATA_W'(trap_pend_q), 3);
        IX_FPU_EN:    rd_val = sext_at(DATA_W'(fpu_q), 0);
        IX_PRIO:      rd_val = sext_at(DATA_W'(prio_q), 4);
        IX_MCHK:      rd_val = sext_at(DATA_W'(mchk_q), 4);
        IX_CTXBLK:    rd_val = sext_at(DATA_W'(CTX_INIT), CTX_MSB);
        IX_PGTBL:     rd_val = PGTBL_INIT;
        IX_VEC_BASE:  rd_val = sext_at(DATA_W'(vec_q), VEC_MSB);
        IX_SWI_SUM:   rd_val = sext_at(DATA_W'(swi_q), 15);
        IX_CPU_ID:    rd_val = CPU_ID_INIT;
        default:      rd_val = '0;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IX_TRAP_EN:   old_val = DATA_W'(trap_en_q);
      IX_TRAP_PEND: old_val = DATA_W'(trap_pend_q);
      IX_PRIO:      old_val = sext_at(DATA_W'(prio_q), 4);
      default:      old_val = '0;
    endcase
  end

  assert_trap_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trap_en |=> trap_en_q == (($past(trap_en_q) & $past(wdata[3:0])) | $past(wdata[7:4])));

  assert_prio_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prio |=> prio_q == $past(wdata[4:0]));

  assert_swi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_swi && wdata[3:0] == 4'd0) |=> $stable(swi_q));

  assert_swi_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_swi |=> ((swi_q & $past(swi_q)) == $past(swi_q)));

  assert_mchk_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mchk |=> (mchk_q[2:0] & $past(wdata[2:0])) == 3'd0 && mchk_q[4:3] == $past(wdata[4:3]));

endmodule

// File: rtl/pcr_flush.sv
module pcr_flush
  import pcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              single,
  input  logic [DATA_W-1:0] addr,
  output logic              pulse,
  output logic              pulse_single,
  output logic [DATA_W-1:0] pulse_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse        <= 1'b0;
      pulse_single <= 1'b0;
      pulse_addr   <= '0;
    end else begin
      pulse        <= fire;
      pulse_single <= fire && single;
      pulse_addr   <= (fire && single) ? addr : '0;
    end
  end

  assert_single_needs_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_single |-> pulse);

endmodule

// File: rtl/pcr_file.sv
module pcr_file
  import pcr_pkg::*;
#(
  parameter int                 ASN_W       = 8,
  parameter int                 CTX_W       = 48,
  parameter int                 VEC_W       = 32,
  parameter logic [ASN_W-1:0]   ASN_INIT    = 8'h2A,
  parameter logic [CTX_W-1:0]   CTX_INIT    = 48'h8000_0000_1000,
  parameter logic [DATA_W-1:0]  PGTBL_INIT  = 64'h0000_0000_0040_0000,
  parameter logic [DATA_W-1:0]  CPU_ID_INIT = 64'h3,
  parameter logic [4:0]         PRIO_INIT   = 5'h1F
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [4:0]        cmd_index,
  input  logic [63:0]       cmd_wdata,
  input  logic              pal_mode,
  input  logic              feat_asn,
  input  logic              feat_vmext,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_old,
  output logic              rsp_error,
  output logic              flush_pulse,
  output logic              flush_single,
  output logic [63:0]       flush_addr
);

  logic              acc_err, has_old, flush_hit, flush_one;
  logic              wr_en, bad_cmd, flush_fire;
  logic [DATA_W-1:0] rd_val, old_val;

  pcr_access u_access (
    .idx        (cmd_index),
    .is_write   (cmd_write),
    .pal_mode   (pal_mode),
    .feat_vmext (feat_vmext),
    .access_err (acc_err),
    .has_old    (has_old),
    .flush_hit  (flush_hit),
    .flush_one  (flush_one)
  );

  assign bad_cmd    = cmd_valid && acc_err;
  assign wr_en      = cmd_valid && cmd_write && !acc_err;
  assign flush_fire = wr_en && flush_hit;

  pcr_bank #(
    .ASN_W(ASN_W), .CTX_W(CTX_W), .VEC_W(VEC_W),
    .ASN_INIT(ASN_INIT), .CTX_INIT(CTX_INIT), .PGTBL_INIT(PGTBL_INIT),
    .CPU_ID_INIT(CPU_ID_INIT), .PRIO_INIT(PRIO_INIT)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .idx      (cmd_index),
    .wdata    (cmd_wdata),
    .feat_asn (feat_asn),
    .rd_val   (rd_val),
    .old_val  (old_val)
  );

  pcr_flush u_flush (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (flush_fire),
    .single       (flush_one),
    .addr         (cmd_wdata),
    .pulse        (flush_pulse),
    .pulse_single (flush_single),
    .pulse_addr   (flush_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_old   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_error <= bad_cmd;
      rsp_old   <= wr_en && has_old;
      if (!cmd_valid || acc_err) rsp_data <= '0;
      else if (cmd_write)        rsp_data <= has_old ? old_val : '0;
      else                       rsp_data <= rd_val;
    end
  end

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  assert_wo_read_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && (cmd_index == IX_SWI_REQ || cmd_index == IX_FL_ALL))
      |=> rsp_error);

  assert_kstack_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_index == IX_KSTACK && !pal_mode) |=> rsp_error);

  assert_flush_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(cmd_valid && cmd_write) && !rsp_error);

  assert_err_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_data == '0 && !rsp_old && !flush_pulse);

endmodule

// File: tb/pcr_file_test.sv
`timescale 1ns/1ps
module pcr_file_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0]  cmd_index = '0;
  logic [63:0] cmd_wdata = '0;
  logic        pal_mode = 1'b0, feat_asn = 1'b0, feat_vmext = 1'b0;
  logic        rsp_valid, rsp_old, rsp_error, flush_pulse, flush_single;
  logic [63:0] rsp_data, flush_addr;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pcr_file uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_index(cmd_index), .cmd_wdata(cmd_wdata), .pal_mode(pal_mode),
    .feat_asn(feat_asn), .feat_vmext(feat_vmext), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_old(rsp_old), .rsp_error(rsp_error),
    .flush_pulse(flush_pulse), .flush_single(flush_single), .flush_addr(flush_addr)
  );

  // reference state
  logic [3:0]  m_ten, m_tpend;
  logic        m_fpu;
  logic [4:0]  m_prio, m_mchk;
  logic [31:0] m_vec;
  logic [15:0] m_swi;
  logic [63:0] m_wide [0:31];

  // expected response
  logic        e_err, e_old, e_fl, e_one;
  logic [63:0] e_data, e_addr;

  function automatic string tag_of(input int ix, input bit wr);
    case (ix)
      0, 15, 23:              return "R11";
      1, 2:                   return "R3";
      5:                      return "R4";
      6:                      return "R10";
      7:                      return "R6";
      12:                     return wr ? "R5" : "R8";
      4:                      return "R8";
      3, 11:                  return "R7";
      8, 13:                  return wr ? "R9" : "R7";
      10, 16, 25:             return "R9";
      17, 18, 19, 20, 21:     return wr ? "R12" : "R8";
      9, 14, 22, 24, 26:      return "R2";
      default:                return "R13";
    endcase
  endfunction

  task automatic model_reset();
    m_ten = 0; m_tpend = 0; m_fpu = 0; m_prio = 5'h1F; m_mchk = 0;
    m_vec = 0; m_swi = 0;
    for (int i = 0; i < 32; i++) m_wide[i] = 64'd0;
  endtask

  task automatic model_step(input bit wr, input int ix, input logic [63:0] d,
                            input bit pal, input bit fasn, input bit fvm);
    e_err = 0; e_old = 0; e_fl = 0; e_one = 0; e_data = 0; e_addr = 0;
    case (ix)
      0: if (wr) e_err = 1; else e_data = fasn ? 64'h2A : 64'h0;
      1: if (wr) begin e_old = 1; e_data = {60'd0, m_ten}; m_ten = (m_ten & d[3:0]) | d[7:4]; end
         else e_data = {{60{m_ten[3]}}, m_ten};
      2: if (wr) begin e_old = 1; e_data = {60'd0, m_tpend}; m_tpend = (m_tpend & d[3:0]) | d[7:4]; end
         else e_data = {{60{m_tpend[3]}}, m_tpend};
      3: if (wr) m_fpu = d[0]; else e_data = {64{m_fpu}};
      4: if (!wr) e_err = 1;
      5: if (wr) begin e_old = 1; e_data = {{59{m_prio[4]}}, m_prio}; m_prio = d[4:0]; end
         else e_data = {{59{m_prio[4]}}, m_prio};
      6: if (!pal) e_err = 1; else if (wr) m_wide[ix] = d; else e_data = m_wide[ix];
      7: if (wr) begin
           for (int b = 0; b < 3; b++) if (d[b]) m_mchk[b] = 1'b0;
           m_mchk[3] = d[3]; m_mchk[4] = d[4];
         end else e_data = {{59{m_mchk[4]}}, m_mchk};
      8: if (wr) e_err = 1; else e_data = 64'hFFFF_8000_0000_1000;
      10: if (wr) e_err = 1; else e_data = 64'h40_0000;
      11: if (wr) m_vec = d[31:0]; else e_data = {{32{m_vec[31]}}, m_vec};
      12: if (!wr) e_err = 1; else if (d[3:0] != 0) m_swi[d[3:0]] = 1'b1;
      13: if (wr) e_err = 1; else e_data = {{48{m_swi[15]}}, m_swi};
      15, 23: if (!fvm) e_err = 1; else if (wr) m_wide[ix] = d; else e_data = m_wide[ix];
      16: if (wr) e_err = 1;
      17, 18: if (!wr) e_err = 1; else e_fl = 1;
      19, 20, 21: if (!wr) e_err = 1; else begin e_fl = 1; e_one = 1; e_addr = d; end
      25: if (wr) e_err = 1; else e_data = 64'h3;
      9, 14, 22, 24, 26: if (wr) m_wide[ix] = d; else e_data = m_wide[ix];
      default: e_err = 1;
    endcase
  endtask

  task automatic check1(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one command at a falling edge, check the response one cycle later.
  task automatic issue(input bit wr, input int ix, input logic [63:0] d,
                       input bit pal, input bit fasn, input bit fvm);
    string t;
    cmd_valid = 1; cmd_write = wr; cmd_index = 5'(ix); cmd_wdata = d;
    pal_mode = pal; feat_asn = fasn; feat_vmext = fvm;
    model_step(wr, ix, d, pal, fasn, fvm);
    t = tag_of(ix, wr);
    @(negedge clk);
    cmd_valid = 0;
    check1(rsp_valid === 1'b1, "R2", "rsp_valid", 64'(rsp_valid), 64'd1);
    check1(rsp_error === e_err, t, $sformatf("error idx%0d wr%0d", ix, wr), 64'(rsp_error), 64'(e_err));
    check1(rsp_data === e_data, t, $sformatf("data idx%0d wr%0d", ix, wr), rsp_data, e_data);
    check1(rsp_old === e_old, t, "old flag", 64'(rsp_old), 64'(e_old));
    check1(flush_pulse === e_fl, t, "flush pulse", 64'(flush_pulse), 64'(e_fl));
    check1(flush_single === e_one, t, "flush single", 64'(flush_single), 64'(e_one));
    check1(flush_addr === e_addr, t, "flush addr", flush_addr, e_addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    check1(rsp_valid === 0 && rsp_error === 0 && rsp_old === 0 && flush_pulse === 0,
           "R1", "reset outputs", {60'd0, rsp_valid, rsp_error, rsp_old, flush_pulse}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check1(rsp_valid === 0, "R1", "idle after reset", 64'(rsp_valid), 64'd0);

    // R1 reset contents
    issue(0, 5, 0, 0, 1, 0);
    issue(0, 25, 0, 0, 1, 0);
    issue(0, 10, 0, 0, 1, 0);
    issue(0, 0, 0, 0, 1, 0);
    // R11 address space number hidden
    issue(0, 0, 0, 0, 0, 0);
    // R7 context base sign extension
    issue(0, 8, 0, 0, 0, 0);
    // R4 back-to-back write then read
    issue(1, 5, 64'h0A, 0, 0, 0);
    issue(1, 5, 64'h13, 0, 0, 0);
    issue(0, 5, 0, 0, 0, 0);
    // R3 merge: set all, then clear bit 2 while setting nothing
    issue(1, 1, 64'hF0, 0, 0, 0);
    issue(1, 1, 64'h0B, 0, 0, 0);
    issue(0, 1, 0, 0, 0, 0);
    issue(1, 2, 64'h9F, 0, 0, 0);
    issue(0, 2, 0, 0, 0, 0);
    // R5 post level 15 and level 0, then read summary
    issue(1, 12, 64'h0F, 0, 0, 0);
    issue(1, 12, 64'h30, 0, 0, 0);
    issue(0, 13, 0, 0, 0, 0);
    // R6 machine check summary
    issue(1, 7, 64'h18, 0, 0, 0);
    issue(0, 7, 0, 0, 0, 0);
    issue(1, 7, 64'h07, 0, 0, 0);
    issue(0, 7, 0, 0, 0, 0);
    // R7 FPU enable and vector base
    issue(1, 3, 64'h1, 0, 0, 0);
    issue(0, 3, 0, 0, 0, 0);
    issue(1, 11, 64'hDEAD_BEEF_8000_0001, 0, 0, 0);
    issue(0, 11, 0, 0, 0, 0);
    // R10 kernel stack gated by mode
    issue(1, 6, 64'h1234, 0, 0, 0);
    issue(1, 6, 64'h5678, 1, 0, 0);
    issue(0, 6, 0, 0, 0, 0);
    issue(0, 6, 0, 1, 0, 0);
    // R11 feature gating
    issue(1, 15, 64'hAAAA, 0, 0, 0);
    issue(1, 15, 64'hBBBB, 0, 0, 1);
    issue(0, 15, 0, 0, 0, 1);
    issue(0, 23, 0, 0, 0, 0);
    // R8 / R9 permissions
    issue(0, 19, 0, 0, 0, 0);
    issue(1, 13, 64'hFFFF, 0, 0, 0);
    issue(0, 13, 0, 0, 0, 0);
    issue(0, 16, 0, 0, 0, 0);
    // R12 flushes back to back
    issue(1, 19, 64'hCAFE_0000, 0, 0, 0);
    issue(1, 17, 64'h1, 0, 0, 0);
    // R13 undefined index
    issue(1, 30, 64'hFFFF_FFFF, 1, 1, 1);
    issue(0, 27, 0, 1, 1, 1);

    for (int n = 0; n < 3000; n++) begin
      automatic int          ix = int'($urandom_range(0, 31));
      automatic bit          wr = 1'($urandom);
      automatic logic [63:0] d  = {$urandom, $urandom};
      issue(wr, ix, d, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule